// File: doc/BRIEF.md
# Resolver Sample Readout Sequencer

This block sits on the controller side of a resolver-to-digital converter and performs one complete angle or velocity readout per request. On a request it pulls the converter's sample strobe low, which freezes the converter's output. It then waits a programmable number of system clocks, drives the two mode-select pins to the position or velocity code, and clocks a 16-bit word in over a serial link with clock polarity 1 and phase 1 (SPI mode 3), most significant bit first. When the transfer ends it raises the strobe again and waits out a hold time before it presents the result.

The raw word is post-processed according to the converter resolution in use, which is 10, 12, 14 or 16 bits. A velocity word is shifted right so that it is right-justified and is sign-extended from its top valid bit. A position word is right-justified only when hysteresis is in use and is otherwise returned unchanged. The result is presented with a single-cycle valid strobe. A busy flag covers the whole sequence. An abort input ends a sequence early while still restoring the strobe and the chip select.

Top module: `rsr_readout`

## Requirements
- R1: After synchronous reset the sample strobe, chip select and serial clock are high, busy and valid are low, and the mode pins show the configuration code (a0=1, a1=0).
- R2: Chip select goes low only while the sample strobe is low, and only after the strobe has been low for at least SETUP_CYC system clocks.
- R3: During a transfer the mode pins are a0=0 with a1=0 for a position read or a1=1 for a velocity read, and they stay stable. When the block is idle again they return to a0=1, a1=0.
- R4: The serial clock idles high and is low between transfers only while chip select is low. The 16 data bits are captured on rising serial clock edges, the first bit being bit 15 of the result word.
- R5: After the transfer the strobe rises, and valid pulses for one cycle exactly HOLD_CYC cycles later. Busy falls in the same cycle as that valid pulse.
- R6: For a position read with hysteresis off, the output equals the raw 16-bit word.
- R7: For a position read with hysteresis on, the output is the raw word shifted right with zero fill by 16 minus the resolution. The resolution is 10 + 2*res_sel_i, so code 0 means 10 bits and code 3 means 16 bits.
- R8: For a velocity read, the output is the raw word shifted right by 16 minus the resolution, with the vacated upper bits copied from raw bit 15. This applies whatever the hysteresis input is.
- R9: A request that arrives while busy is high is ignored: it starts no second sequence and gives no second valid pulse.
- R10: An abort during the wait or the transfer drives chip select and the strobe high on the next clock. Busy falls after the hold time, and no valid pulse is produced.
- R11: The read type, resolution and hysteresis setting are captured at the request. Changing these inputs during a sequence has no effect on that sequence's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Start one readout (sampled when idle) |
| abort_i | input | 1 | End the running sequence without a result |
| vel_sel_i | input | 1 | 1 = velocity read, 0 = position read |
| res_sel_i | input | 2 | Resolution code, resolution = 10 + 2*code |
| hyst_en_i | input | 1 | Hysteresis in use (affects position alignment) |
| sample_n_o | output | 1 | Sample strobe to the converter, active low |
| mode_a0_o | output | 1 | Mode-select pin 0 |
| mode_a1_o | output | 1 | Mode-select pin 1 |
| sclk_o | output | 1 | Serial clock, idle high |
| cs_n_o | output | 1 | Serial chip select, active low |
| miso_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | Sequence in progress |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 16 | Aligned result, held until the next valid |

## Verification
A vector table drives position reads with hysteresis off and on at several resolutions, and velocity reads with positive, negative and all-ones raw words. Positive and negative words show whether the sign fill is done, and the different resolution codes show whether the shift amount is right. The converter model returns a different word for each mode-pin code, so a wrong pin code shows up as a wrong result. The same table also checks the strobe-to-select wait and the hold time. Directed cases cover reset, a repeated request with changed settings while busy, and aborts during the wait and during the transfer.

// File: rtl/rsr_pkg.sv
// Package: shared types for the resolver readout sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rsr_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2,
        ST_HOLD  = 2'd3
    } rd_state_e;

    // Read settings captured at the request
    typedef struct packed {
        logic       vel;
        logic       hyst;
        logic [1:0] res;
    } rd_cfg_t;

endpackage

// File: rtl/rsr_spi_rx.sv
// Module: serial receiver, clock polarity 1 / phase 1, MSB first.
// Drives chip select low on start and toggles the serial clock every
// SCLK_HALF system clocks. Each rising serial edge shifts in one bit.
// After WORD_W bits and one further half period it releases chip select
// and pulses done. Assumes: SCLK_HALF >= 1; start is ignored while active.
module rsr_spi_rx #(
    parameter int WORD_W    = 16,
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int DIV_W = (SCLK_HALF < 2) ? 1 : $clog2(SCLK_HALF);
    localparam int NB_W  = $clog2(WORD_W + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);
    localparam logic [NB_W-1:0]  NB_LAST  = NB_W'(WORD_W);

    logic              active_q;
    logic              sclk_q;
    logic              cs_n_q;
    logic              done_q;
    logic [DIV_W-1:0]  div_q;
    logic [NB_W-1:0]   nbit_q;
    logic [WORD_W-1:0] shift_q;
    logic              edge_due;

    assign edge_due = active_q && (div_q == DIV_LAST);

    // Frame control, clock generation and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b1;
            cs_n_q   <= 1'b1;
            done_q   <= 1'b0;
            div_q    <= '0;
            nbit_q   <= '0;
            shift_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (abort_i) begin
                active_q <= 1'b0;
                sclk_q   <= 1'b1;
                cs_n_q   <= 1'b1;
            end else if (start_i && !active_q) begin
                active_q <= 1'b1;
                cs_n_q   <= 1'b0;
                sclk_q   <= 1'b1;
                div_q    <= '0;
                nbit_q   <= '0;
            end else if (active_q) begin
                if (!edge_due) begin
                    div_q <= div_q + 1'b1;
                end else begin
                    div_q <= '0;
                    if (nbit_q == NB_LAST) begin
                        active_q <= 1'b0;
                        cs_n_q   <= 1'b1;
                        done_q   <= 1'b1;
                    end else if (sclk_q) begin
                        sclk_q <= 1'b0;
                    end else begin
                        sclk_q  <= 1'b1;
                        shift_q <= {shift_q[WORD_W-2:0], miso_i};
                        nbit_q  <= nbit_q + 1'b1;
                    end
                end
            end
        end
    end

    assign sclk_o = sclk_q;
    assign cs_n_o = cs_n_q;
    assign done_o = done_q;
    assign word_o = shift_q;

endmodule

// File: rtl/rsr_align.sv
// Module: resolution alignment of the raw word (combinational).
// Resolution = MIN_RES + RES_STEP * code. Velocity words are shifted
// arithmetically (sign fill from the top raw bit). Position words are
// shifted logically only when hysteresis is set, otherwise passed as is.
// Assumes: MIN_RES + 3*RES_STEP <= WORD_W.
module rsr_align #(
    parameter int WORD_W   = 16,
    parameter int MIN_RES  = 10,
    parameter int RES_STEP = 2
) (
    input  logic [WORD_W-1:0] raw_i,
    input  logic [1:0]        res_sel_i,
    input  logic              vel_i,
    input  logic              hyst_i,
    output logic [WORD_W-1:0] data_o
);
    localparam int SH_W = $clog2(WORD_W + 1);

    logic [SH_W-1:0] shamt;

    // Shift amount from the resolution code
    always_comb begin
        shamt = SH_W'(WORD_W - MIN_RES) - SH_W'(RES_STEP * int'(res_sel_i));
    end

    // Mode-dependent alignment
    always_comb begin
        if (vel_i) begin
            data_o = WORD_W'($signed(raw_i) >>> shamt);
        end else if (hyst_i) begin
            data_o = raw_i >> shamt;
        end else begin
            data_o = raw_i;
        end
    end

endmodule

// File: rtl/rsr_readout.sv
// Module: resolver sample readout sequencer (top).
// Sequence per request: strobe low -> wait SETUP_CYC -> mode pins and
// serial read -> strobe high -> wait HOLD_CYC -> valid pulse.
// Assumes: SETUP_CYC >= 1, HOLD_CYC >= 1, SCLK_HALF >= 1; requests
// arriving while busy are dropped; abort acts in setup and transfer.
module rsr_readout #(
    parameter int WORD_W    = 16,
    parameter int SETUP_CYC = 6,
    parameter int HOLD_CYC  = 2,
    parameter int SCLK_HALF = 2,
    parameter int MIN_RES   = 10,
    parameter int RES_STEP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              abort_i,
    input  logic              vel_sel_i,
    input  logic [1:0]        res_sel_i,
    input  logic              hyst_en_i,
    output logic              sample_n_o,
    output logic              mode_a0_o,
    output logic              mode_a1_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [WORD_W-1:0] data_o
);
    import rsr_pkg::*;

    localparam int CNT_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

    rd_state_e         state_q;
    rd_cfg_t           cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              aborted_q;
    logic              sample_n_q;
    logic              a0_q;
    logic              a1_q;
    logic              valid_q;
    logic [WORD_W-1:0] result_q;

    logic              spi_start;
    logic              spi_abort;
    logic              spi_done;
    logic [WORD_W-1:0] spi_word;
    logic [WORD_W-1:0] aligned;

    // Transfer start at the end of the setup wait unless aborted
    assign spi_start = (state_q == ST_SETUP) && (cnt_q == SETUP_LAST) && !abort_i;
    assign spi_abort = (state_q == ST_XFER) && abort_i;

    rsr_spi_rx #(
        .WORD_W    (WORD_W),
        .SCLK_HALF (SCLK_HALF)
    ) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (spi_start),
        .abort_i (spi_abort),
        .miso_i  (miso_i),
        .sclk_o  (sclk_o),
        .cs_n_o  (cs_n_o),
        .done_o  (spi_done),
        .word_o  (spi_word)
    );

    rsr_align #(
        .WORD_W   (WORD_W),
        .MIN_RES  (MIN_RES),
        .RES_STEP (RES_STEP)
    ) u_align (
        .raw_i     (spi_word),
        .res_sel_i (cfg_q.res),
        .vel_i     (cfg_q.vel),
        .hyst_i    (cfg_q.hyst),
        .data_o    (aligned)
    );

    // Sequencer: strobe, mode pins, waits and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cfg_q      <= '0;
            cnt_q      <= '0;
            aborted_q  <= 1'b0;
            sample_n_q <= 1'b1;
            a0_q       <= 1'b1;
            a1_q       <= 1'b0;
            valid_q    <= 1'b0;
            result_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        cfg_q      <= '{vel: vel_sel_i, hyst: hyst_en_i, res: res_sel_i};
                        sample_n_q <= 1'b0;
                        cnt_q      <= '0;
                        aborted_q  <= 1'b0;
                        state_q    <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (abort_i) begin
                        sample_n_q <= 1'b1;
                        aborted_q  <= 1'b1;
                        cnt_q      <= '0;
                        state_q    <= ST_HOLD;
                    end else if (spi_start) begin
                        a0_q    <= 1'b0;
                        a1_q    <= cfg_q.vel;
                        state_q <= ST_XFER;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (abort_i) begin
                        sample_n_q <= 1'b1;
                        aborted_q  <= 1'b1;
                        cnt_q      <= '0;
                        state_q    <= ST_HOLD;
                    end else if (spi_done) begin
                        result_q   <= aligned;
                        sample_n_q <= 1'b1;
                        cnt_q      <= '0;
                        state_q    <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (cnt_q == HOLD_LAST) begin
                        valid_q <= !aborted_q;
                        a0_q    <= 1'b1;
                        a1_q    <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sample_n_o = sample_n_q;
    assign mode_a0_o  = a0_q;
    assign mode_a1_o  = a1_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign valid_o    = valid_q;
    assign data_o     = result_q;

endmodule

// File: rtl/rsr_checker.sv
// Module: protocol checker for rsr_readout, attached by bind.
// Counts cycles the strobe has been low or high (saturating) so that
// the wait windows are checked without deep $past.
module rsr_checker #(
    parameter int SETUP_CYC = 6,
    parameter int HOLD_CYC  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sample_n_o,
    input logic mode_a0_o,
    input logic mode_a1_o,
    input logic sclk_o,
    input logic cs_n_o,
    input logic busy_o,
    input logic valid_o
);
    logic [15:0] low_cnt;
    logic [15:0] high_cnt;

    // Strobe-level duration counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            low_cnt  <= sample_n_o ? 16'd0 : ((&low_cnt)  ? low_cnt  : low_cnt  + 16'd1);
            high_cnt <= !sample_n_o ? 16'd0 : ((&high_cnt) ? high_cnt : high_cnt + 16'd1);
        end
    end

    AST_CS_UNDER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) !cs_n_o |-> !sample_n_o); // R2
    AST_SETUP_WAIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n_o) |-> (low_cnt >= 16'(SETUP_CYC))); // R2
    AST_MODE_READ_CODE: assert property (@(posedge clk) disable iff (!rst_n) !cs_n_o |-> !mode_a0_o); // R3
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n_o && $past(!cs_n_o)) |-> $stable(mode_a1_o)); // R3
    AST_IDLE_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (mode_a0_o && !mode_a1_o)); // R3
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) cs_n_o |-> sclk_o); // R4
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> (high_cnt >= 16'(HOLD_CYC))); // R5
    AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> (!busy_o && $past(busy_o))); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o); // R5
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (sample_n_o && cs_n_o)); // R10

endmodule

bind rsr_readout rsr_checker #(
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC)
) u_chk (.*);

// File: tb/sim_rsr_readout.sv
module sim_rsr_readout;
    localparam int CLK_P     = 10;
    localparam int SETUP_CYC = 6;
    localparam int HOLD_CYC  = 2;
    localparam int NVEC      = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        abort = 1'b0;
    logic        vel_sel = 1'b0;
    logic [1:0]  res_sel = 2'd0;
    logic        hyst_en = 1'b0;
    logic        miso = 1'b1;
    logic        sample_n, a0, a1, sclk, cs_n, busy, valid;
    logic [15:0] data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // converter model words, one per mode-pin code
    logic [15:0] pos_word = 16'h0000;
    logic [15:0] vel_word = 16'h0000;
    int          bit_idx = 15;

    // monitor state
    int          low_cyc = 0;
    int          hi_cyc = 0;
    int          setup_seen = 0;
    logic        cs_prev = 1'b1;
    logic [1:0]  mode_seen = 2'b11;
    logic        sample_at_cs = 1'b1;
    int          valid_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    rsr_readout #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .abort_i(abort),
        .vel_sel_i(vel_sel), .res_sel_i(res_sel), .hyst_en_i(hyst_en),
        .sample_n_o(sample_n), .mode_a0_o(a0), .mode_a1_o(a1),
        .sclk_o(sclk), .cs_n_o(cs_n), .miso_i(miso),
        .busy_o(busy), .valid_o(valid), .data_o(data)
    );

    // converter model: next bit on each falling serial edge, MSB first
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            bit_idx = 15;
        end else begin
            miso = a1 ? vel_word[bit_idx] : pos_word[bit_idx];
            bit_idx = bit_idx - 1;
        end
    end

    // bench monitor on the falling system clock edge
    always @(negedge clk) begin
        if (!cs_n && cs_prev) begin
            setup_seen   <= low_cyc;
            mode_seen    <= {a0, a1};
            sample_at_cs <= sample_n;
        end
        low_cyc   <= sample_n ? 0 : low_cyc + 1;
        hi_cyc    <= sample_n ? hi_cyc + 1 : 0;
        cs_prev   <= cs_n;
        if (valid) valid_cnt <= valid_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic v, input logic h, input logic [1:0] r);
        @(negedge clk);
        vel_sel = v; hyst_en = h; res_sel = r; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_valid(output logic [15:0] got, output bit seen, output int hold);
        seen = 1'b0; got = '0; hold = 0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (valid) begin seen = 1'b1; got = data; hold = hi_cyc; end
        end
    endtask

    // {vel, hyst, res[1:0], raw[15:0], expected[15:0]}
    localparam logic [35:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 2'd0, 16'hABCD, 16'hABCD},
        {1'b0, 1'b0, 2'd2, 16'h0001, 16'h0001},
        {1'b0, 1'b1, 2'd0, 16'hABCD, 16'h02AF},
        {1'b0, 1'b1, 2'd1, 16'hABCD, 16'h0ABC},
        {1'b0, 1'b1, 2'd2, 16'hFFFF, 16'h3FFF},
        {1'b0, 1'b1, 2'd3, 16'hABCD, 16'hABCD},
        {1'b1, 1'b0, 2'd0, 16'h8000, 16'hFE00},
        {1'b1, 1'b0, 2'd1, 16'h7FF0, 16'h07FF},
        {1'b1, 1'b0, 2'd2, 16'hFFFC, 16'hFFFF},
        {1'b1, 1'b0, 2'd2, 16'h4000, 16'h1000},
        {1'b1, 1'b0, 2'd3, 16'h1234, 16'h1234},
        {1'b1, 1'b1, 2'd1, 16'hABCD, 16'hFABC}
    };

    initial begin
        logic [15:0] got;
        bit seen;
        int hold;
        int vbefore;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(sample_n && cs_n && sclk, "R1 pins", {sample_n, cs_n, sclk}, 3'b111);
        check(!busy && !valid, "R1 flags", {busy, valid}, 2'b00);
        check(a0 && !a1, "R1 mode", {a0, a1}, 2'b10);
        rst_n = 1'b1;

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            logic [35:0] v;
            string tag;
            v = VEC[k];
            tag = v[35] ? "R4 R8" : (v[34] ? "R4 R7" : "R4 R6");
            pos_word = v[35] ? ~v[31:16] : v[31:16];
            vel_word = v[35] ? v[31:16] : ~v[31:16];
            pulse_req(v[35], v[34], v[33:32]);
            check(busy, "R5 busy", busy, 1);
            wait_valid(got, seen, hold);
            check(seen && got == v[15:0], tag, got, v[15:0]);
            check(setup_seen >= SETUP_CYC && !sample_at_cs, "R2 setup", setup_seen, SETUP_CYC);
            check(mode_seen == {1'b0, v[35]}, "R3 mode", mode_seen, {1'b0, v[35]});
            check(hold == HOLD_CYC && !busy, "R5 hold", hold, HOLD_CYC);
            @(negedge clk);
            check(!valid && a0 && !a1, "R3 R5 idle", {valid, a0, a1}, 3'b010);
        end

        // R9 R11: second request with other settings while busy
        pos_word = 16'h5A5A; vel_word = 16'hC3C3;
        vbefore = valid_cnt;
        pulse_req(1'b0, 1'b0, 2'd0);
        while (cs_n) @(negedge clk);
        vel_sel = 1'b1; hyst_en = 1'b1; res_sel = 2'd3; req = 1'b1;
        @(negedge clk); req = 1'b0;
        wait_valid(got, seen, hold);
        check(seen && got == 16'h5A5A, "R11 settings", got, 16'h5A5A);
        repeat (60) @(negedge clk);
        check(valid_cnt == vbefore + 1 && !busy, "R9 ignored", valid_cnt - vbefore, 1);

        // R10: abort during transfer
        vbefore = valid_cnt;
        pulse_req(1'b1, 1'b0, 2'd1);
        while (cs_n) @(negedge clk);
        repeat (5) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        check(cs_n && sample_n, "R10 release xfer", {cs_n, sample_n}, 2'b11);
        repeat (HOLD_CYC + 3) @(negedge clk);
        check(!busy && valid_cnt == vbefore, "R10 no result xfer", valid_cnt - vbefore, 0);

        // R10: abort during the setup wait
        pulse_req(1'b0, 1'b0, 2'd0);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        check(cs_n && sample_n, "R10 release setup", {cs_n, sample_n}, 2'b11);
        repeat (HOLD_CYC + 20) @(negedge clk);
        check(!busy && valid_cnt == vbefore && cs_n, "R10 no result setup", valid_cnt - vbefore, 0);

        // recovery after abort
        pos_word = 16'h8001; vel_word = 16'h0000;
        pulse_req(1'b0, 1'b1, 2'd3);
        wait_valid(got, seen, hold);
        check(seen && got == 16'h8001, "R7 after abort", got, 16'h8001);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule